// File: doc/BRIEF.md
# Synchronous Character Receiver with Sync Hunt and Strip

This block receives a synchronous serial stream for byte-oriented link protocols. Each data bit arrives on `rx_bit` together with a one-cycle receive strobe `rx_stb`, which marks the bit time of an external line clock. The first bit received on the line is the least significant bit of a character. While `rx_go` is high the receiver hunts for a programmable sync pattern. On every strobe it compares the most recent field-length bits against that pattern. Once it has locked, it cuts the stream into characters of programmable length (2 to 16 bits) and delivers each one with a one-cycle valid pulse.

Per-character parity checking can be enabled, with the parity bit taken as the last bit of the field. The receiver can require one sync field or two back-to-back sync fields before it declares lock. Sync fields that arrive after lock can optionally be dropped rather than delivered. Each delivered character is compared against a programmable detect value, and the match can raise an interrupt pulse if that is enabled. A watchdog flags the loss of the line clock while the receiver is enabled.

The sequencer has three states:
- `ST_HUNT`: bit-by-bit search.
- `ST_WAIT2`: one sync field seen, and the next whole field must also be a sync field.
- `ST_FRAME`: locked and framing characters.

It has these transitions:
- HUNT to FRAME on a match in single-sync mode.
- HUNT to WAIT2 on a match in double-sync mode.
- WAIT2 to FRAME when the following field matches.
- WAIT2 to HUNT when the following field does not match.
- Any state to HUNT when `rx_go` is low.

Top module: `sync_char_rx`

## Requirements
- R1: While hunting, on every strobe the receiver compares the latest L bits against `cfg_sync[L-1:0]`, where L is the effective field length. The oldest of those L bits is bit 0. In single-sync mode, `rx_synced` is high in the cycle after the strobe that carries the final bit of the matching field.
- R2: With `cfg_dbl_sync`=1, one sync field leaves `rx_synced` low. A second sync field that immediately follows it sets `rx_synced`. Any other field in that position sends the receiver back to hunting.
- R3: Once locked, each following group of L bits is one character, with its first bit in bit 0. `rx_valid` pulses for exactly one cycle, in the cycle after the strobe that carries the last bit of the character, and `rx_data` holds the character at that time.
- R4: With `cfg_strip`=1, a field that equals the sync pattern and arrives after lock produces no `rx_valid` pulse. With `cfg_strip`=0, such a field is delivered like any other character.
- R5: With `cfg_par_en`=1, bit L-1 of the field is the parity bit. `rx_data` carries bits L-2..0 with zeros above them. `rx_par_err` is high alongside `rx_valid` when the number of ones in all L bits is odd (for `cfg_par_odd`=0) or even (for `cfg_par_odd`=1). Otherwise it is low.
- R6: `rx_char_det` is high alongside `rx_valid` when the delivered data equals `cfg_det_char` masked to the data width. `rx_det_irq` is high only when `rx_char_det` is high and `cfg_det_ie`=1.
- R7: While `rx_go` is low the receiver is held in hunt, `rx_synced` is low from the next cycle on, a partly received character is discarded, and no character is delivered.
- R8: With `rx_go` high, `rx_clk_loss` becomes set once `cfg_loss_limit` system clocks have passed with no strobe. It stays set until `rx_go` goes low, which clears it on the next cycle.
- R9: After reset, `rx_valid`, `rx_synced`, `rx_par_err`, `rx_char_det`, `rx_det_irq` and `rx_clk_loss` are all low.
- R10: The effective length L is `cfg_len` clamped to the range 2..16. The full 16-bit length is supported for sync, data and detect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_go | input | 1 | Receiver enable; low forces hunt |
| rx_stb | input | 1 | One-cycle bit strobe from the line clock |
| rx_bit | input | 1 | Serial data bit, sampled with `rx_stb` |
| cfg_len | input | 5 | Field length in bits, parity bit included |
| cfg_sync | input | 16 | Sync pattern, low L bits used |
| cfg_dbl_sync | input | 1 | 1 = two contiguous sync fields needed |
| cfg_strip | input | 1 | 1 = drop sync fields received after lock |
| cfg_par_en | input | 1 | 1 = last field bit is parity |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_det_char | input | 16 | Detect value |
| cfg_det_ie | input | 1 | Enables `rx_det_irq` |
| cfg_loss_limit | input | 16 | System clocks without a strobe before clock loss |
| rx_data | output | 16 | Received character |
| rx_valid | output | 1 | One-cycle character strobe |
| rx_synced | output | 1 | Lock acquired |
| rx_par_err | output | 1 | Parity error for the current character |
| rx_char_det | output | 1 | Detect match for the current character |
| rx_det_irq | output | 1 | Detect interrupt pulse |
| rx_clk_loss | output | 1 | Receive clock loss, sticky while enabled |

## Verification
Lock, character and flag results all appear one register stage after the strobe edge that samples the decisive bit. The bench drives each bit with a one-cycle strobe at a falling edge. It then reads `rx_synced`, `rx_valid` and the qualifier flags at the very next falling edge, so that the rising edge in between has loaded them. A monitor pops the expected character from a scoreboard queue on every `rx_valid` pulse. The send task also checks, at the falling edge right after each last bit, whether a pulse was or was not due (dropped sync fields and failed double-sync attempts are both checked this way). Clock loss is checked with margins on both sides of the limit plus one cycles.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_WAIT2 = 2'd1,
        ST_FRAME = 2'd2
    } rx_state_t;

endpackage

// File: rtl/srx_shifter.sv
module srx_shifter #(
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               stb,
    input  logic               bit_in,
    input  logic [LEN_W-1:0]   len,
    output logic [MAX_LEN-1:0] field_nx
);

    logic [MAX_LEN-1:0] hist;
    logic [MAX_LEN-1:0] hist_nx;
    logic [LEN_W-1:0]   sh_amt;

    // newest bit enters at the top, so the oldest bit of the window is bit 0
    always_comb begin
        hist_nx  = {bit_in, hist[MAX_LEN-1:1]};
        sh_amt   = LEN_W'(MAX_LEN) - len;
        field_nx = hist_nx >> sh_amt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (clear) begin
            hist <= '0;
        end else if (stb) begin
            hist <= hist_nx;
        end
    end

endmodule

// File: rtl/srx_seq.sv
module srx_seq
    import sync_rx_pkg::*;
#(
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             stb,
    input  logic [LEN_W-1:0] len,
    input  logic             sync_hit,
    input  logic             dbl_sync,
    input  logic             strip,
    output logic             emit,
    output logic             synced
);

    rx_state_t        state, state_nx;
    logic [LEN_W-1:0] cnt, cnt_nx;
    logic             last_bit;

    assign last_bit = (cnt == len - LEN_W'(1));
    assign synced   = (state == ST_FRAME);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HUNT;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // next state and outputs
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        emit     = 1'b0;
        if (!go) begin
            state_nx = ST_HUNT;
            cnt_nx   = '0;
        end else if (stb) begin
            unique case (state)
                ST_HUNT: begin
                    if (sync_hit) begin
                        state_nx = dbl_sync ? ST_WAIT2 : ST_FRAME;
                        cnt_nx   = '0;
                    end
                end
                ST_WAIT2: begin
                    if (last_bit) begin
                        cnt_nx   = '0;
                        state_nx = sync_hit ? ST_FRAME : ST_HUNT;
                    end else begin
                        cnt_nx = cnt + LEN_W'(1);
                    end
                end
                ST_FRAME: begin
                    if (last_bit) begin
                        cnt_nx = '0;
                        emit   = !(strip && sync_hit);
                    end else begin
                        cnt_nx = cnt + LEN_W'(1);
                    end
                end
                default: state_nx = ST_HUNT;
            endcase
        end
    end

    // R7
    go_low_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> !synced);

    // R1
    lock_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(synced) |-> $past(stb));

    // R3
    bit_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_HUNT) |-> (cnt < len));

endmodule

// File: rtl/srx_char_out.sv
module srx_char_out #(
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               emit,
    input  logic [MAX_LEN-1:0] field,
    input  logic [LEN_W-1:0]   len,
    input  logic               par_en,
    input  logic               par_odd,
    input  logic [MAX_LEN-1:0] det_char,
    input  logic               det_ie,
    output logic [MAX_LEN-1:0] data,
    output logic               valid,
    output logic               par_err,
    output logic               det,
    output logic               det_irq
);

    logic [LEN_W-1:0]   dlen;
    logic [MAX_LEN-1:0] dmask;
    logic [MAX_LEN-1:0] dval;
    logic               perr_c;
    logic               det_c;

    always_comb begin
        dlen   = par_en ? (len - LEN_W'(1)) : len;
        dmask  = ~({MAX_LEN{1'b1}} << dlen);
        dval   = field & dmask;
        perr_c = par_en && ((^field) ^ par_odd);
        det_c  = (dval == (det_char & dmask));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data    <= '0;
            valid   <= 1'b0;
            par_err <= 1'b0;
            det     <= 1'b0;
            det_irq <= 1'b0;
        end else begin
            valid   <= emit;
            par_err <= emit && perr_c;
            det     <= emit && det_c;
            det_irq <= emit && det_c && det_ie;
            if (emit) begin
                data <= dval;
            end
        end
    end

    // R5
    par_err_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> valid);

    // R6
    det_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        det |-> valid);

    // R6
    irq_needs_det_chk: assert property (@(posedge clk) disable iff (!rst_n)
        det_irq |-> det);

endmodule

// File: rtl/srx_loss_mon.sv
module srx_loss_mon #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             stb,
    input  logic [CNT_W-1:0] limit,
    output logic             loss
);

    logic [CNT_W-1:0] idle_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_cnt <= '0;
            loss     <= 1'b0;
        end else begin
            if (!go || stb) begin
                idle_cnt <= '0;
            end else if (idle_cnt != limit) begin
                idle_cnt <= idle_cnt + CNT_W'(1);
            end
            if (!go) begin
                loss <= 1'b0;
            end else if (idle_cnt == limit) begin
                loss <= 1'b1;
            end
        end
    end

    // R8
    loss_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> !loss);

    // R8
    loss_only_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loss) |-> $past(go));

endmodule

// File: rtl/sync_char_rx.sv
module sync_char_rx
    import sync_rx_pkg::*;
#(
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = $clog2(MAX_LEN + 1),
    parameter int LOSS_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_go,
    input  logic               rx_stb,
    input  logic               rx_bit,
    input  logic [LEN_W-1:0]   cfg_len,
    input  logic [MAX_LEN-1:0] cfg_sync,
    input  logic               cfg_dbl_sync,
    input  logic               cfg_strip,
    input  logic               cfg_par_en,
    input  logic               cfg_par_odd,
    input  logic [MAX_LEN-1:0] cfg_det_char,
    input  logic               cfg_det_ie,
    input  logic [LOSS_W-1:0]  cfg_loss_limit,
    output logic [MAX_LEN-1:0] rx_data,
    output logic               rx_valid,
    output logic               rx_synced,
    output logic               rx_par_err,
    output logic               rx_char_det,
    output logic               rx_det_irq,
    output logic               rx_clk_loss
);

    localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(2);
    localparam logic [LEN_W-1:0] TOP_LEN = LEN_W'(MAX_LEN);

    logic [LEN_W-1:0]   len_eff;
    logic [MAX_LEN-1:0] fmask;
    logic [MAX_LEN-1:0] field_nx;
    logic               sync_hit;
    logic               emit;

    // R10 length clamp
    always_comb begin
        if (cfg_len < MIN_LEN) begin
            len_eff = MIN_LEN;
        end else if (cfg_len > TOP_LEN) begin
            len_eff = TOP_LEN;
        end else begin
            len_eff = cfg_len;
        end
        fmask    = ~({MAX_LEN{1'b1}} << len_eff);
        sync_hit = (field_nx == (cfg_sync & fmask));
    end

    srx_shifter #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!rx_go),
        .stb      (rx_stb),
        .bit_in   (rx_bit),
        .len      (len_eff),
        .field_nx (field_nx)
    );

    srx_seq #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (rx_go),
        .stb      (rx_stb),
        .len      (len_eff),
        .sync_hit (sync_hit),
        .dbl_sync (cfg_dbl_sync),
        .strip    (cfg_strip),
        .emit     (emit),
        .synced   (rx_synced)
    );

    srx_char_out #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .emit     (emit),
        .field    (field_nx),
        .len      (len_eff),
        .par_en   (cfg_par_en),
        .par_odd  (cfg_par_odd),
        .det_char (cfg_det_char),
        .det_ie   (cfg_det_ie),
        .data     (rx_data),
        .valid    (rx_valid),
        .par_err  (rx_par_err),
        .det      (rx_char_det),
        .det_irq  (rx_det_irq)
    );

    srx_loss_mon #(.CNT_W(LOSS_W)) u_loss (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (rx_go),
        .stb   (rx_stb),
        .limit (cfg_loss_limit),
        .loss  (rx_clk_loss)
    );

    // R3
    valid_while_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> rx_synced);

    // R7
    no_char_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_go |=> !rx_valid);

endmodule

// File: tb/sim_sync_char_rx.sv
module sim_sync_char_rx;

    localparam int MAX_LEN = 16;
    localparam int LEN_W   = 5;
    localparam int LOSS_W  = 16;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               rx_go, rx_stb, rx_bit;
    logic [LEN_W-1:0]   cfg_len;
    logic [MAX_LEN-1:0] cfg_sync, cfg_det_char;
    logic               cfg_dbl_sync, cfg_strip, cfg_par_en, cfg_par_odd, cfg_det_ie;
    logic [LOSS_W-1:0]  cfg_loss_limit;
    logic [MAX_LEN-1:0] rx_data;
    logic               rx_valid, rx_synced, rx_par_err, rx_char_det, rx_det_irq, rx_clk_loss;

    always #4 clk = ~clk;

    sync_char_rx u0 (.*);

    typedef struct packed {
        logic [15:0] d;
        logic        pe;
        logic        dt;
        logic        irq;
    } exp_t;

    exp_t expq[$];
    int   checks = 0;
    int   errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && rx_valid) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R3", "unexpected character", int'(rx_data), 0);
            end else begin
                e = expq.pop_front();
                chk(rx_data == e.d, "R3", "data", int'(rx_data), int'(e.d));
                chk(rx_par_err == e.pe, "R5", "parity error", int'(rx_par_err), int'(e.pe));
                chk(rx_char_det == e.dt, "R6", "detect", int'(rx_char_det), int'(e.dt));
                chk(rx_det_irq == e.irq, "R6", "detect irq", int'(rx_det_irq), int'(e.irq));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        report();
        $finish;
    end

    task automatic push(input logic [15:0] d, input logic pe, input logic dt, input logic irq);
        exp_t e;
        e.d = d; e.pe = pe; e.dt = dt; e.irq = irq;
        expq.push_back(e);
    endtask

    // drive a field lsb first; after its last bit, check whether a valid pulse is due
    task automatic send_field(input logic [15:0] val, input int len,
                              input bit do_chk, input bit expv, input string req);
        for (int i = 0; i < len; i++) begin
            rx_bit = val[i];
            rx_stb = 1'b1;
            @(negedge clk);
            rx_stb = 1'b0;
            if (do_chk && i == len - 1)
                chk(rx_valid == expv, req, "valid timing", int'(rx_valid), int'(expv));
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic restart();
        rx_go = 1'b0;
        repeat (2) @(negedge clk);
        rx_go = 1'b1;
        @(negedge clk);
    endtask

    task automatic setup(input int len, input logic [15:0] sync, input bit pen, input bit podd,
                         input bit strip, input bit dbl, input logic [15:0] det, input bit ie);
        rx_go        = 1'b0;
        cfg_len      = LEN_W'(len);
        cfg_sync     = sync;
        cfg_par_en   = pen;
        cfg_par_odd  = podd;
        cfg_strip    = strip;
        cfg_dbl_sync = dbl;
        cfg_det_char = det;
        cfg_det_ie   = ie;
        restart();
    endtask

    task automatic drain(input string req);
        repeat (4) @(negedge clk);
        chk(expq.size() == 0, req, "queue empty", expq.size(), 0);
    endtask

    initial begin
        rst_n = 1'b0; rx_go = 1'b0; rx_stb = 1'b0; rx_bit = 1'b0;
        cfg_len = 5'd8; cfg_sync = 16'h16; cfg_dbl_sync = 1'b0; cfg_strip = 1'b0;
        cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_det_char = 16'h0; cfg_det_ie = 1'b0;
        cfg_loss_limit = 16'd1000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(rx_valid == 0, "R9", "valid", int'(rx_valid), 0);
        chk(rx_synced == 0, "R9", "synced", int'(rx_synced), 0);
        chk(rx_par_err == 0, "R9", "par_err", int'(rx_par_err), 0);
        chk(rx_char_det == 0, "R9", "char_det", int'(rx_char_det), 0);
        chk(rx_det_irq == 0, "R9", "det_irq", int'(rx_det_irq), 0);
        chk(rx_clk_loss == 0, "R9", "clk_loss", int'(rx_clk_loss), 0);

        // R1 single sync, R3 framing, R4 no strip delivers sync
        setup(8, 16'h16, 0, 0, 0, 0, 16'h0, 0);
        send_field(16'hFF, 8, 0, 0, "R1");
        chk(rx_synced == 0, "R1", "no lock before sync", int'(rx_synced), 0);
        send_field(16'h16, 8, 0, 0, "R1");
        chk(rx_synced == 1, "R1", "lock after sync", int'(rx_synced), 1);
        push(16'h41, 0, 0, 0); send_field(16'h41, 8, 1, 1, "R3");
        push(16'hC3, 0, 0, 0); send_field(16'hC3, 8, 1, 1, "R3");
        push(16'h16, 0, 0, 0); send_field(16'h16, 8, 1, 1, "R4");
        drain("R3");

        // R4 strip on
        setup(8, 16'h16, 0, 0, 1, 0, 16'h0, 0);
        send_field(16'hFF, 8, 0, 0, "R1");
        send_field(16'h16, 8, 0, 0, "R1");
        push(16'h55, 0, 0, 0); send_field(16'h55, 8, 1, 1, "R3");
        send_field(16'h16, 8, 1, 0, "R4");
        send_field(16'h16, 8, 1, 0, "R4");
        chk(rx_synced == 1, "R4", "still locked", int'(rx_synced), 1);
        push(16'h0F, 0, 0, 0); send_field(16'h0F, 8, 1, 1, "R4");
        drain("R4");

        // R5 even parity, 9-bit field
        setup(9, 16'h116, 1, 0, 0, 0, 16'h0, 0);
        send_field(16'h1FF, 9, 0, 0, "R5");
        send_field(16'h116, 9, 0, 0, "R5");
        push(16'h41, 0, 0, 0); send_field(16'h041, 9, 1, 1, "R5");
        push(16'h41, 1, 0, 0); send_field(16'h141, 9, 1, 1, "R5");
        drain("R5");
        // R5 odd parity
        setup(9, 16'h116, 1, 1, 0, 0, 16'h0, 0);
        send_field(16'h1FF, 9, 0, 0, "R5");
        send_field(16'h116, 9, 0, 0, "R5");
        push(16'h41, 0, 0, 0); send_field(16'h141, 9, 1, 1, "R5");
        push(16'h40, 1, 0, 0); send_field(16'h140, 9, 1, 1, "R5");
        drain("R5");

        // R6 detect with and without interrupt enable
        setup(8, 16'h16, 0, 0, 0, 0, 16'h42, 1);
        send_field(16'hFF, 8, 0, 0, "R6");
        send_field(16'h16, 8, 0, 0, "R6");
        push(16'h41, 0, 0, 0); send_field(16'h41, 8, 1, 1, "R6");
        push(16'h42, 0, 1, 1); send_field(16'h42, 8, 1, 1, "R6");
        cfg_det_ie = 1'b0;
        push(16'h42, 0, 1, 0); send_field(16'h42, 8, 1, 1, "R6");
        drain("R6");

        // R2 double sync
        setup(8, 16'h16, 0, 0, 0, 1, 16'h0, 0);
        send_field(16'hFF, 8, 0, 0, "R2");
        send_field(16'h16, 8, 0, 0, "R2");
        chk(rx_synced == 0, "R2", "one sync not enough", int'(rx_synced), 0);
        send_field(16'h41, 8, 1, 0, "R2");
        chk(rx_synced == 0, "R2", "non-sync follow", int'(rx_synced), 0);
        send_field(16'hFF, 8, 0, 0, "R2");
        send_field(16'h16, 8, 0, 0, "R2");
        send_field(16'h16, 8, 0, 0, "R2");
        chk(rx_synced == 1, "R2", "two syncs lock", int'(rx_synced), 1);
        push(16'h33, 0, 0, 0); send_field(16'h33, 8, 1, 1, "R2");
        drain("R2");

        // R10 16-bit fields
        setup(16, 16'h2D96, 0, 0, 0, 0, 16'hBEEF, 1);
        send_field(16'hFFFF, 16, 0, 0, "R10");
        send_field(16'h2D96, 16, 0, 0, "R10");
        chk(rx_synced == 1, "R10", "16-bit lock", int'(rx_synced), 1);
        push(16'hBEEF, 0, 1, 1); send_field(16'hBEEF, 16, 1, 1, "R10");
        push(16'h0001, 0, 0, 0); send_field(16'h0001, 16, 1, 1, "R10");
        drain("R10");

        // R7 go low mid character
        setup(8, 16'h16, 0, 0, 0, 0, 16'h0, 0);
        send_field(16'hFF, 8, 0, 0, "R7");
        send_field(16'h16, 8, 0, 0, "R7");
        send_field(16'h05, 3, 0, 0, "R7");
        rx_go = 1'b0;
        @(negedge clk);
        chk(rx_synced == 0, "R7", "unlock on go low", int'(rx_synced), 0);
        rx_go = 1'b1;
        send_field(16'h1F, 5, 1, 0, "R7");
        chk(rx_synced == 0, "R7", "hunting after re-enable", int'(rx_synced), 0);
        drain("R7");

        // R8 clock loss
        rx_go = 1'b0;
        cfg_loss_limit = 16'd20;
        repeat (2) @(negedge clk);
        rx_go = 1'b1;
        repeat (15) @(negedge clk);
        chk(rx_clk_loss == 0, "R8", "before limit", int'(rx_clk_loss), 0);
        repeat (10) @(negedge clk);
        chk(rx_clk_loss == 1, "R8", "after limit", int'(rx_clk_loss), 1);
        send_field(16'h1, 1, 0, 0, "R8");
        chk(rx_clk_loss == 1, "R8", "sticky", int'(rx_clk_loss), 1);
        rx_go = 1'b0;
        repeat (2) @(negedge clk);
        chk(rx_clk_loss == 0, "R8", "cleared by go low", int'(rx_clk_loss), 0);

        report();
        $finish;
    end

endmodule